// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between an internal request port and an external asynchronous static RAM of 32,768 bytes. Each request is one read or one write of a single byte, offered with a valid/ready handshake. The controller turns it into a timed sequence of active-low chip-enable, write-enable and output-enable strobes. It also drives the 15-bit address and a data-out value with a separate driver-enable for the bidirectional byte bus, and it captures the byte the memory returns on a read.

All timing intervals are parameters counted in clock cycles:

| Parameter | Meaning |
|---|---|
| `T_ACC` | read access count |
| `T_WP` | minimum write strobe overlap |
| `T_AW` | address-to-write-end |
| `T_SETUP` | data setup before the write ends |
| `T_TURN` | bus turnaround after the write strobes fall |
| `T_HOLD` | data hold after the write ends |

The memory writes only while chip enable and write enable are both low, and the write ends when either of them rises. `CE_CONTROLLED` picks which strobe ends the write. Setup and hold are counted from that strobe's rising edge. The address is held from the start of an access until every strobe is high again. The controller's data driver waits out the memory's output turn-off time before it drives the bus.

Every access ends with a one-cycle `done` pulse. For reads, `rdata` is valid in that same cycle.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, `sram_ce_n`, `sram_we_n` and `sram_oe_n` are 1, `sram_dq_oe` is 0, `done` is 0 and `req_ready` is 1.
- R2: A read pulls `sram_ce_n` and `sram_oe_n` low on the accept edge and keeps them low for exactly `T_ACC` cycles, with `sram_we_n` held at 1. The bus is sampled on the edge where both rise, and the byte appears on `rdata` while `done` is 1 in the following cycle.
- R3: `sram_addr` takes the request address on the accept edge. It does not change again until a cycle in which all three strobes have been 1.
- R4: A write pulls `sram_ce_n` and `sram_we_n` low together on the accept edge. Both stay low (the overlap) for OV = max(`T_WP`, `T_AW`, `T_TURN` + max(`T_SETUP`,1)) cycles. The terminating strobe then rises: `sram_we_n` when `CE_CONTROLLED`=0, `sram_ce_n` when it is 1. The other strobe rises max(`T_HOLD`,1) cycles later.
- R5: During the first `T_TURN` overlap cycles `sram_dq_oe` is 0. For the remaining OV−`T_TURN` overlap cycles it is 1, and `sram_dq_out` does not change while it is 1.
- R6: The data driver is on for at least `T_SETUP` cycles before the terminating strobe rises. It turns off on that same edge when `T_HOLD`=0, or stays on for exactly `T_HOLD` more cycles otherwise.
- R7: `sram_oe_n` stays 1 for the whole of a write. `sram_dq_oe` is never 1 while `sram_oe_n` is 0, so the controller and the memory never drive the bus together.
- R8: `req_ready` is 1 only when no access is in progress and all strobes are 1. Each accepted request produces exactly one `done` pulse, one cycle wide.
- R9: A read returns the byte most recently written to that address, including addresses 0x0000 and 0x7FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| req_valid | input | 1 | request offered |
| req_ready | output | 1 | controller idle, request accepted when valid is also high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | byte address |
| req_wdata | input | 8 | write byte |
| done | output | 1 | one-cycle completion pulse |
| rdata | output | 8 | read byte, valid with done after a read |
| sram_addr | output | 15 | memory address |
| sram_ce_n | output | 1 | chip enable, active low |
| sram_we_n | output | 1 | write enable, active low |
| sram_oe_n | output | 1 | output enable, active low |
| sram_dq_out | output | 8 | byte driven onto the data bus |
| sram_dq_oe | output | 1 | data driver enable for the bus |
| sram_dq_in | input | 8 | byte read from the data bus |

## Verification
The bound checker enforces the following on every cycle:
- address stability while any strobe is low;
- output enable held off during writes, and no overlap between the driver and output enable;
- the minimum overlap and setup windows, counted at the end of every write;
- the terminating strobe rising before the other one;
- the hold behaviour and the turnaround on the falling write strobe;
- `done` as a single-cycle pulse.

The bench's scenarios show what the checker cannot:
- the exact cycle counts of every strobe and of the driver;
- that each written byte really lands in a memory model and comes back through a read at edge addresses;
- that both write-ending styles behave correctly. This is shown with two controllers built with different timing parameters.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WTURN,
        ST_WDATA,
        ST_WTAIL
    } seq_state_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
    } strobe_s;

    localparam strobe_s STROBE_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Strobe pattern for each sequencer state; the tail keeps only the
    // non-terminating strobe low.
    function automatic strobe_s decode_strobes(input seq_state_e st, input logic ce_ends);
        strobe_s s;
        s = STROBE_IDLE;
        case (st)
            ST_READ:            s = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0};
            ST_WTURN, ST_WDATA: s = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1};
            ST_WTAIL:           s = ce_ends ? '{ce_n: 1'b1, we_n: 1'b0, oe_n: 1'b1}
                                            : '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1};
            default:            s = STROBE_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int T_ACC         = 1,
    parameter int T_WP          = 1,
    parameter int T_AW          = 1,
    parameter int T_SETUP       = 1,
    parameter int T_TURN        = 1,
    parameter int T_HOLD        = 0,
    parameter int CE_CONTROLLED = 0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    req_fire,
    input  logic    req_write,
    output logic    idle,
    output strobe_s strobes,
    output logic    dq_oe,
    output logic    capture,
    output logic    done
);
    // Driven cycles inside the overlap: enough for setup, pulse width and
    // address-to-end once the turnaround has been spent.
    localparam int DATA_CYC = imax(imax(T_SETUP, 1), imax(T_WP - T_TURN, T_AW - T_TURN));
    localparam int TAIL_CYC = imax(T_HOLD, 1);
    localparam int MAX_CYC  = imax(imax(T_ACC, T_TURN), imax(DATA_CYC, TAIL_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] ACC_LD  = CNT_W'(T_ACC - 1);
    localparam logic [CNT_W-1:0] DATA_LD = CNT_W'(DATA_CYC - 1);
    localparam logic [CNT_W-1:0] TAIL_LD = CNT_W'(TAIL_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(T_TURN - 1);

    seq_state_e       state, nxt;
    logic             load, expired, fin, tail_drive;
    logic [CNT_W-1:0] load_val;
    seq_state_e       first_wr;
    logic [CNT_W-1:0] first_ld;

    generate
        if (T_TURN > 0) begin : g_turn
            assign first_wr = ST_WTURN;
            assign first_ld = TURN_LD;
        end else begin : g_noturn
            assign first_wr = ST_WDATA;
            assign first_ld = DATA_LD;
        end
        if (T_HOLD > 0) begin : g_hold
            assign tail_drive = 1'b1;
        end else begin : g_nohold
            assign tail_drive = 1'b0;
        end
    endgenerate

    sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .load_val(load_val),
        .expired (expired)
    );

    always_comb begin
        nxt      = state;
        load     = 1'b0;
        load_val = '0;
        fin      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_fire) begin
                    load = 1'b1;
                    if (req_write) begin
                        nxt      = first_wr;
                        load_val = first_ld;
                    end else begin
                        nxt      = ST_READ;
                        load_val = ACC_LD;
                    end
                end
            end
            ST_READ: begin
                if (expired) begin
                    nxt = ST_IDLE;
                    fin = 1'b1;
                end
            end
            ST_WTURN: begin
                if (expired) begin
                    nxt      = ST_WDATA;
                    load     = 1'b1;
                    load_val = DATA_LD;
                end
            end
            ST_WDATA: begin
                if (expired) begin
                    nxt      = ST_WTAIL;
                    load     = 1'b1;
                    load_val = TAIL_LD;
                end
            end
            ST_WTAIL: begin
                if (expired) begin
                    nxt = ST_IDLE;
                    fin = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            strobes <= STROBE_IDLE;
            dq_oe   <= 1'b0;
            done    <= 1'b0;
        end else begin
            state   <= nxt;
            strobes <= decode_strobes(nxt, CE_CONTROLLED != 0);
            dq_oe   <= (nxt == ST_WDATA) || (tail_drive && (nxt == ST_WTAIL));
            done    <= fin;
        end
    end

    assign idle    = (state == ST_IDLE);
    assign capture = (state == ST_READ) && expired;
endmodule

// File: rtl/sram_ctrl_rdcap.sv
module sram_ctrl_rdcap #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (capture) begin
            rdata <= bus_in;
        end
    end
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 15,
    parameter int DATA_W        = 8,
    parameter int T_ACC         = 1,
    parameter int T_WP          = 1,
    parameter int T_AW          = 1,
    parameter int T_SETUP       = 1,
    parameter int T_TURN        = 1,
    parameter int T_HOLD        = 0,
    parameter int CE_CONTROLLED = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    strobe_s           strobes;
    logic              req_fire, idle, capture;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    assign req_ready = idle;
    assign req_fire  = req_valid && idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (req_fire) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    sram_ctrl_seq #(
        .T_ACC        (T_ACC),
        .T_WP         (T_WP),
        .T_AW         (T_AW),
        .T_SETUP      (T_SETUP),
        .T_TURN       (T_TURN),
        .T_HOLD       (T_HOLD),
        .CE_CONTROLLED(CE_CONTROLLED)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_fire (req_fire),
        .req_write(req_write),
        .idle     (idle),
        .strobes  (strobes),
        .dq_oe    (sram_dq_oe),
        .capture  (capture),
        .done     (done)
    );

    sram_ctrl_rdcap #(.DATA_W(DATA_W)) u_rdcap (
        .clk    (clk),
        .rst    (rst),
        .capture(capture),
        .bus_in (sram_dq_in),
        .rdata  (rdata)
    );

    assign sram_addr   = addr_q;
    assign sram_dq_out = wdata_q;
    assign sram_ce_n   = strobes.ce_n;
    assign sram_we_n   = strobes.we_n;
    assign sram_oe_n   = strobes.oe_n;
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
    parameter int ADDR_W        = 15,
    parameter int DATA_W        = 8,
    parameter int T_WP          = 1,
    parameter int T_AW          = 1,
    parameter int T_SETUP       = 1,
    parameter int T_TURN        = 1,
    parameter int T_HOLD        = 0,
    parameter int CE_CONTROLLED = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              done,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              ce_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              dq_oe,
    input logic [DATA_W-1:0] dq_out
);
    logic        ov, ov_q, term_n, other_n;
    logic [31:0] ov_cnt, drv_cnt;

    assign ov      = !ce_n && !we_n;
    assign term_n  = (CE_CONTROLLED != 0) ? ce_n : we_n;
    assign other_n = (CE_CONTROLLED != 0) ? we_n : ce_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            ov_q    <= 1'b0;
            ov_cnt  <= '0;
            drv_cnt <= '0;
        end else begin
            ov_q    <= ov;
            ov_cnt  <= ov ? ov_cnt + 32'd1 : 32'd0;
            drv_cnt <= !ov ? 32'd0 : (dq_oe ? drv_cnt + 32'd1 : drv_cnt);
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (ce_n && we_n && oe_n && !dq_oe && !done));

    assert_addr_stable_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(sram_addr) |-> $past(ce_n && we_n && oe_n));

    assert_overlap_len_R4: assert property (@(posedge clk) disable iff (rst)
        (ov_q && !ov) |-> (ov_cnt >= 32'(T_WP) && ov_cnt >= 32'(T_AW)));

    assert_term_first_R4: assert property (@(posedge clk) disable iff (rst)
        (ov_q && !ov) |-> (term_n && !other_n));

    assert_data_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (dq_oe && $past(dq_oe)) |-> $stable(dq_out));

    generate
        if (T_TURN > 0) begin : g_turn_chk
            assert_turnaround_R5: assert property (@(posedge clk) disable iff (rst)
                $fell(we_n) |-> !dq_oe);
        end else begin : g_noturn_chk
            assert_turnaround_R5: assert property (@(posedge clk) disable iff (rst)
                $fell(we_n) |-> dq_oe);
        end
        if (T_HOLD > 0) begin : g_hold_chk
            assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
                (ov_q && !ov) |-> dq_oe);
        end else begin : g_nohold_chk
            assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
                (ov_q && !ov) |-> !dq_oe);
        end
    endgenerate

    assert_setup_R6: assert property (@(posedge clk) disable iff (rst)
        (ov_q && !ov) |-> (drv_cnt >= 32'(T_SETUP)));

    assert_no_oe_write_R7: assert property (@(posedge clk) disable iff (rst)
        (!we_n || dq_oe) |-> oe_n);

    assert_ready_idle_R8: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (ce_n && we_n && oe_n && !dq_oe));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind sram_strobe_ctrl sram_ctrl_chk #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .T_WP         (T_WP),
    .T_AW         (T_AW),
    .T_SETUP      (T_SETUP),
    .T_TURN       (T_TURN),
    .T_HOLD       (T_HOLD),
    .CE_CONTROLLED(CE_CONTROLLED)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_ready(req_ready),
    .done     (done),
    .sram_addr(sram_addr),
    .ce_n     (sram_ce_n),
    .we_n     (sram_we_n),
    .oe_n     (sram_oe_n),
    .dq_oe    (sram_dq_oe),
    .dq_out   (sram_dq_out)
);

// File: tb/async_sram_model.sv
module async_sram_model #(
    parameter int AW = 15,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [DW-1:0] din,
    input  logic          din_en,
    output logic [DW-1:0] q,
    output logic          q_en
);
    logic [DW-1:0] mem [int];
    logic [DW-1:0] pend  = '0;
    logic [AW-1:0] wa    = '0;
    logic          act_q = 1'b0;

    assign q_en = !ce_n && !oe_n && we_n;

    // Sampled mid-cycle: the write commits once the strobe overlap is gone.
    always @(negedge clk) begin
        if (!ce_n && !we_n) begin
            if (din_en) pend = din;
            wa    = addr;
            act_q = 1'b1;
        end else if (act_q) begin
            mem[int'(wa)] = pend;
            act_q = 1'b0;
        end
        q = mem.exists(int'(addr)) ? mem[int'(addr)] : '0;
    end
endmodule

// File: tb/test_sram_strobe_ctrl.sv
`timescale 1ns/1ps
module test_sram_strobe_ctrl;
    // Configuration A: write ends on write enable; B: write ends on chip enable.
    localparam int A_ACC = 3, A_WP = 4, A_AW = 3, A_SU = 2, A_TURN = 1, A_HOLD = 1;
    localparam int B_ACC = 2, B_WP = 2, B_AW = 2, B_SU = 1, B_TURN = 0, B_HOLD = 0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic valid = 1'b0, wr = 1'b0, sel = 1'b0;
    logic [14:0] addr = '0;
    logic [7:0]  wdata = '0;
    int tests = 0, fails = 0;

    always #2 clk = ~clk;

    logic ready_a, done_a, ce_a, we_a, oe_a, dqoe_a, qen_a;
    logic ready_b, done_b, ce_b, we_b, oe_b, dqoe_b, qen_b;
    logic [7:0]  rdata_a, dqo_a, q_a, dqi_a, rdata_b, dqo_b, q_b, dqi_b;
    logic [14:0] ao_a, ao_b;

    assign dqi_a = qen_a ? q_a : 8'h00;
    assign dqi_b = qen_b ? q_b : 8'h00;

    sram_strobe_ctrl #(.T_ACC(A_ACC), .T_WP(A_WP), .T_AW(A_AW), .T_SETUP(A_SU),
        .T_TURN(A_TURN), .T_HOLD(A_HOLD), .CE_CONTROLLED(0)) i_sram_strobe_ctrl (
        .clk(clk), .rst(rst), .req_valid(valid && !sel), .req_ready(ready_a),
        .req_write(wr), .req_addr(addr), .req_wdata(wdata), .done(done_a), .rdata(rdata_a),
        .sram_addr(ao_a), .sram_ce_n(ce_a), .sram_we_n(we_a), .sram_oe_n(oe_a),
        .sram_dq_out(dqo_a), .sram_dq_oe(dqoe_a), .sram_dq_in(dqi_a));

    sram_strobe_ctrl #(.T_ACC(B_ACC), .T_WP(B_WP), .T_AW(B_AW), .T_SETUP(B_SU),
        .T_TURN(B_TURN), .T_HOLD(B_HOLD), .CE_CONTROLLED(1)) i_sram_strobe_ctrl_cec (
        .clk(clk), .rst(rst), .req_valid(valid && sel), .req_ready(ready_b),
        .req_write(wr), .req_addr(addr), .req_wdata(wdata), .done(done_b), .rdata(rdata_b),
        .sram_addr(ao_b), .sram_ce_n(ce_b), .sram_we_n(we_b), .sram_oe_n(oe_b),
        .sram_dq_out(dqo_b), .sram_dq_oe(dqoe_b), .sram_dq_in(dqi_b));

    async_sram_model u_mem_a (.clk(clk), .addr(ao_a), .ce_n(ce_a), .we_n(we_a), .oe_n(oe_a),
        .din(dqo_a), .din_en(dqoe_a), .q(q_a), .q_en(qen_a));
    async_sram_model u_mem_b (.clk(clk), .addr(ao_b), .ce_n(ce_b), .we_n(we_b), .oe_n(oe_b),
        .din(dqo_b), .din_en(dqoe_b), .q(q_b), .q_en(qen_b));

    logic        ready_s, done_s, ce_s, we_s, oe_s, dqoe_s, qen_s;
    logic [7:0]  rdata_s;
    logic [14:0] ao_s;
    assign ready_s = sel ? ready_b : ready_a;
    assign done_s  = sel ? done_b  : done_a;
    assign ce_s    = sel ? ce_b    : ce_a;
    assign we_s    = sel ? we_b    : we_a;
    assign oe_s    = sel ? oe_b    : oe_a;
    assign dqoe_s  = sel ? dqoe_b  : dqoe_a;
    assign qen_s   = sel ? qen_b   : qen_a;
    assign rdata_s = sel ? rdata_b : rdata_a;
    assign ao_s    = sel ? ao_b    : ao_a;

    logic [7:0] ref_a [int];
    logic [7:0] ref_b [int];
    logic [8:0] exp_q [$];
    logic [8:0] e;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Expected counts from the requirement formulas.
    function automatic int ov_len(input bit s);
        if (s) return mx(mx(B_WP, B_AW), B_TURN + mx(B_SU, 1));
        return mx(mx(A_WP, A_AW), A_TURN + mx(A_SU, 1));
    endfunction

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (!rst && done_s) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 done without request", 1, 0);
            end else begin
                e = exp_q.pop_front();
                if (!e[8]) chk(rdata_s == e[7:0], "R9 read data", int'(rdata_s), int'(e[7:0]));
            end
        end
    end

    task automatic run_req(input bit s, input bit w, input logic [14:0] a, input logic [7:0] d);
        int n_cyc = 0, n_ce = 0, n_we = 0, n_oe = 0, n_dq = 0, n_ov = 0, n_ovdq = 0;
        int n_badaddr = 0, n_rdy = 0, n_fight = 0;
        int ov, tail, turn, hold, acc;
        ov   = ov_len(s);
        turn = s ? B_TURN : A_TURN;
        hold = s ? B_HOLD : A_HOLD;
        acc  = s ? B_ACC : A_ACC;
        tail = mx(hold, 1);
        if (w) begin
            if (s) ref_b[int'(a)] = d; else ref_a[int'(a)] = d;
            exp_q.push_back({1'b1, 8'h00});
        end else begin
            exp_q.push_back({1'b0, s ? ref_b[int'(a)] : ref_a[int'(a)]});
        end
        @(negedge clk);
        sel = s; valid = 1'b1; wr = w; addr = a; wdata = d;
        while (!ready_s) @(negedge clk);
        while (1) begin
            @(negedge clk);
            valid = 1'b0;
            if (done_s || n_cyc > 60) break;
            n_cyc++;
            n_ce      += int'(!ce_s);
            n_we      += int'(!we_s);
            n_oe      += int'(!oe_s);
            n_dq      += int'(dqoe_s);
            n_ov      += int'(!ce_s && !we_s);
            n_ovdq    += int'(!ce_s && !we_s && dqoe_s);
            n_badaddr += int'(ao_s != a);
            n_rdy     += int'(ready_s);
            n_fight   += int'(dqoe_s && qen_s);
        end
        chk(n_badaddr == 0, "R3 address held during access", n_badaddr, 0);
        chk(n_rdy == 0, "R8 ready low while busy", n_rdy, 0);
        if (w) begin
            chk(n_ov == ov, "R4 overlap length", n_ov, ov);
            chk(n_ce == (s ? ov : ov + tail), "R4 chip enable low cycles", n_ce, s ? ov : ov + tail);
            chk(n_we == (s ? ov + tail : ov), "R4 write enable low cycles", n_we, s ? ov + tail : ov);
            chk(n_ovdq == ov - turn, "R5 driven cycles inside overlap", n_ovdq, ov - turn);
            chk(n_dq == ov - turn + hold, "R6 total driven cycles", n_dq, ov - turn + hold);
            chk(n_oe == 0 && n_fight == 0, "R7 output enable during write", n_oe + n_fight, 0);
        end else begin
            chk(n_ce == acc && n_oe == acc, "R2 read strobe cycles", n_ce * 100 + n_oe, acc * 101);
            chk(n_we == 0 && n_dq == 0, "R2 read leaves write path idle", n_we + n_dq, 0);
            chk(n_fight == 0, "R7 no bus contention on read", n_fight, 0);
        end
        @(negedge clk);
        chk(!done_s, "R8 done one cycle wide", int'(done_s), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ce_a && we_a && oe_a && !dqoe_a && ready_a && !done_a, "R1 reset idle WE-ended",
            int'({ce_a, we_a, oe_a, dqoe_a, ready_a, done_a}), 6'b111010);
        chk(ce_b && we_b && oe_b && !dqoe_b && ready_b && !done_b, "R1 reset idle CE-ended",
            int'({ce_b, we_b, oe_b, dqoe_b, ready_b, done_b}), 6'b111010);
        for (int s = 0; s < 2; s++) begin
            run_req(s[0], 1'b1, 15'h0000, 8'hA5);
            run_req(s[0], 1'b1, 15'h7FFF, 8'h3C);
            run_req(s[0], 1'b1, 15'h1234, 8'hFF);
            run_req(s[0], 1'b1, 15'h0001, 8'h00);
            run_req(s[0], 1'b0, 15'h0000, 8'h00);
            run_req(s[0], 1'b0, 15'h7FFF, 8'h00);
            run_req(s[0], 1'b0, 15'h1234, 8'h00);
            run_req(s[0], 1'b0, 15'h0001, 8'h00);
            run_req(s[0], 1'b1, 15'h1234, 8'h81);
            run_req(s[0], 1'b0, 15'h1234, 8'h00);
            run_req(s[0], 1'b0, 15'h1234, 8'h00);
            run_req(s[0], 1'b1, 15'h5555, 8'h5A);
            run_req(s[0], 1'b1, 15'h5555, 8'hC3);
            run_req(s[0], 1'b0, 15'h5555, 8'h00);
        end
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R8 every request completed", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL R8 watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule